// File: doc/BRIEF.md
# Byte-Wide Memory DMA Engine

This block copies whole words between an on-chip word-addressed memory and an off-chip memory with an 8-bit data bus. Software sets up the transfer through a small register port. It writes the internal word address, the low 14 bits of the external byte address, a control word and a wait-state count. Writing a non-zero word count then starts the transfer at once. The control word holds the 8-bit external page, the direction and the packing mode. Page and low field together form a 22-bit external byte address.

For every external byte the engine runs one bus cycle. The cycle is one setup clock with chip enable active, then the read or write strobe for (wait states + 1) clocks, then one hold clock. In the read direction the bytes are gathered into a 24-bit word and written to internal memory. In the write direction the bytes are taken from the internal word. The count is in words, and it can be polled. When the count reaches zero the engine returns to idle and pulses an interrupt.

Top module: `byte_dma_engine`

## Requirements
- R1: After reset the engine is idle: busy and interrupt are low, all three strobes are high (inactive), the count reads 0 and the wait-state count is 7.
- R2: The external address is {page, low field}, 22 bits wide. It advances by one after each byte, and a carry out of the low 14 bits increments the page.
- R3: Register selects are 0 internal address, 1 external low field, 2 control, 3 wait states (bits 2:0) and 4 word count. A non-zero count write while idle starts the transfer: busy is high from the next clock. A count write of zero starts nothing.
- R4: The count reads back at all times and drops by one at the end of each word. When it reaches zero, busy falls and the interrupt is high for exactly one clock at the same moment.
- R5: Control layout: bits 15:8 page, bit 2 direction (1 = internal to external, 0 = external to internal), bits 1:0 packing mode.
- R6: Packing mode 0 moves one byte per word in bits 7:0. Mode 1 moves one byte in bits 15:8. Mode 2 moves two bytes, bits 7:0 first and then bits 15:8. Mode 3 moves three bytes, bits 7:0, then 15:8, then 23:16. On a read, word bits that the mode does not fill are written as zero.
- R7: In the write direction each byte is driven from the selected lane of the internal word, in the mode's order, with the data bus drive enable high.
- R8: Each byte takes (wait states + 3) clocks: setup, strobe for (wait states + 1) clocks, hold. A transfer therefore lasts words × bytes-per-word × (wait states + 3) clocks from the count write to the interrupt. Read data is sampled on the last strobe clock.
- R9: Any register write while busy is ignored, including a new count.
- R10: The internal address advances by one per word. In the read direction the word is written once, during the hold clock of its last byte.
- R11: Write and output enable are never active together, and a strobe is active only while chip enable is active and the address is held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| count_o | output | 14 | Remaining word count |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | One-clock completion pulse |
| mem_addr_o | output | 14 | Internal word address |
| mem_we_o | output | 1 | Internal word write |
| mem_wdata_o | output | 24 | Internal word write data |
| mem_rdata_i | input | 24 | Internal word read data (combinational) |
| ext_addr_o | output | 22 | External byte address |
| ext_dout_o | output | 8 | External write data |
| ext_din_i | input | 8 | External read data |
| ext_drive_o | output | 1 | External data bus drive enable |
| ext_ce_n_o | output | 1 | Chip enable, active low |
| ext_we_n_o | output | 1 | Write enable, active low |
| ext_oe_n_o | output | 1 | Output enable, active low |

## Verification
Busy rises one clock after the accepted count write. The first strobe falls one clock after that. The interrupt pulse arrives exactly words × bytes-per-word × (wait states + 3) clocks after the count-write edge, and the count falls one clock after the hold of each word's last byte. The bench drives at falling edges and samples at falling edges. It counts falling edges from the count write, so the transfer length, the one-clock interrupt width and the mid-transfer count are each compared at the exact clock where they are due. Strobe widths and the first address of each strobe are taken at rising edges from the values of the clock just ended, so each width equals (wait states + 1) exactly.

// File: rtl/byte_dma_pkg.sv
// Shared types and helpers for the byte-wide DMA engine.
// Assumes a 24-bit internal word split into three byte lanes.
package byte_dma_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 3;
    localparam int WORD_W = BYTE_W * LANES;

    typedef enum logic [1:0] {
        PK_LO8 = 2'd0,
        PK_HI8 = 2'd1,
        PK_16  = 2'd2,
        PK_24  = 2'd3
    } pack_e;

    typedef enum logic [2:0] {
        SEL_IADDR = 3'd0,
        SEL_ELOW  = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_WAITS = 3'd3,
        SEL_COUNT = 3'd4
    } sel_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD
    } phase_e;

    // Number of external bytes moved per internal word.
    function automatic logic [1:0] bytes_per_word(pack_e m);
        case (m)
            PK_16:   return 2'd2;
            PK_24:   return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

    // Word lane used by the byte at position idx of a word.
    function automatic logic [1:0] lane_of(pack_e m, logic [1:0] idx);
        return (m == PK_HI8) ? 2'd1 : idx;
    endfunction
endpackage

// File: rtl/byte_dma_regs.sv
// Configuration and address/count registers of the DMA engine.
// Assumes advance pulses only occur while busy; writes are accepted only when idle.
module byte_dma_regs
    import byte_dma_pkg::*;
#(
    parameter int IADDR_W = 14,
    parameter int ELOW_W  = 14,
    parameter int PAGE_W  = 8,
    parameter int CNT_W   = 14,
    parameter int WS_W    = 3,
    parameter int CFG_W   = 16,
    localparam int EXT_W  = ELOW_W + PAGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               busy,
    input  logic               byte_adv,
    input  logic               word_adv,
    output logic [IADDR_W-1:0] iaddr,
    output logic [EXT_W-1:0]   ext_addr,
    output logic               dir_wr,
    output pack_e              mode,
    output logic [WS_W-1:0]    waits,
    output logic [CNT_W-1:0]   count,
    output logic               start,
    output logic               last_word
);
    localparam int DIR_BIT = 2;

    logic accept;

    // Register writes are taken only while idle.
    assign accept    = cfg_we && !busy;
    assign start     = accept && (sel_e'(cfg_sel) == SEL_COUNT) && (cfg_wdata[CNT_W-1:0] != '0);
    assign last_word = (count == CNT_W'(1));

    // Hold configuration, advance addresses and count during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iaddr    <= '0;
            ext_addr <= '0;
            dir_wr   <= 1'b0;
            mode     <= PK_LO8;
            waits    <= '1;
            count    <= '0;
        end else begin
            if (accept) begin
                case (sel_e'(cfg_sel))
                    SEL_IADDR: iaddr <= cfg_wdata[IADDR_W-1:0];
                    SEL_ELOW:  ext_addr[ELOW_W-1:0] <= cfg_wdata[ELOW_W-1:0];
                    SEL_CTRL: begin
                        ext_addr[EXT_W-1:ELOW_W] <= cfg_wdata[CFG_W-1 -: PAGE_W];
                        dir_wr <= cfg_wdata[DIR_BIT];
                        mode   <= pack_e'(cfg_wdata[1:0]);
                    end
                    SEL_WAITS: waits <= cfg_wdata[WS_W-1:0];
                    SEL_COUNT: count <= cfg_wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
            if (byte_adv) ext_addr <= ext_addr + EXT_W'(1);
            if (word_adv) begin
                iaddr <= iaddr + IADDR_W'(1);
                count <= count - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/byte_dma_seq.sv
// Byte-cycle sequencer: setup, strobe for waits+1 clocks, hold, per byte.
// Assumes mode, direction and waits stay constant while busy.
module byte_dma_seq
    import byte_dma_pkg::*;
#(
    parameter int WS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [WS_W-1:0] waits,
    input  pack_e           mode,
    input  logic            dir_wr,
    input  logic            last_word,
    output phase_e          phase,
    output logic [1:0]      byte_idx,
    output logic            byte_adv,
    output logic            word_adv,
    output logic            sample,
    output logic            irq
);
    logic [WS_W-1:0] wcnt;
    logic            last_byte;

    assign last_byte = (byte_idx == bytes_per_word(mode) - 2'd1);
    assign byte_adv  = (phase == PH_HOLD);
    assign word_adv  = byte_adv && last_byte;
    assign sample    = (phase == PH_STROBE) && (wcnt == '0) && !dir_wr;

    // Phase machine, wait counter, byte index and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            wcnt     <= '0;
            byte_idx <= '0;
            irq      <= 1'b0;
        end else begin
            irq <= word_adv && last_word;
            case (phase)
                PH_IDLE: if (start) begin
                    phase    <= PH_SETUP;
                    byte_idx <= '0;
                end
                PH_SETUP: begin
                    phase <= PH_STROBE;
                    wcnt  <= waits;
                end
                PH_STROBE: begin
                    if (wcnt == '0) phase <= PH_HOLD;
                    else            wcnt  <= wcnt - WS_W'(1);
                end
                PH_HOLD: begin
                    if (last_byte) begin
                        byte_idx <= '0;
                        phase    <= last_word ? PH_IDLE : PH_SETUP;
                    end else begin
                        byte_idx <= byte_idx + 2'd1;
                        phase    <= PH_SETUP;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/byte_dma_pack.sv
// Byte lane steering: picks the outgoing byte of a word and gathers incoming bytes.
// Assumes the internal read data is valid in the same clock as its address.
module byte_dma_pack
    import byte_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  pack_e             mode,
    input  logic [1:0]        byte_idx,
    input  logic              sample,
    input  logic [BYTE_W-1:0] ext_din,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] ext_dout,
    output logic [WORD_W-1:0] mem_wdata
);
    logic [1:0] lane;

    assign lane = lane_of(mode, byte_idx);

    // Select the outgoing byte lane of the current word.
    always_comb begin
        ext_dout = '0;
        for (int l = 0; l < LANES; l++)
            if (lane == 2'(l)) ext_dout = mem_rdata[l*BYTE_W +: BYTE_W];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] asm_q;
        // Capture this lane's byte, clearing it at the first byte of a word.
        always_ff @(posedge clk) begin
            if (!rst_n)                         asm_q <= '0;
            else if (sample && lane == 2'(g))   asm_q <= ext_din;
            else if (sample && byte_idx == '0)  asm_q <= '0;
        end
        assign mem_wdata[g*BYTE_W +: BYTE_W] = asm_q;
    end
endmodule

// File: rtl/byte_dma_engine.sv
// Top of the byte-wide DMA engine: moves words between internal memory and a
// byte-wide external memory with programmable wait states and packing.
// Assumes internal memory is not modified by others during a transfer.
module byte_dma_engine
    import byte_dma_pkg::*;
#(
    parameter int IADDR_W = 14,
    parameter int ELOW_W  = 14,
    parameter int PAGE_W  = 8,
    parameter int CNT_W   = 14,
    parameter int WS_W    = 3,
    parameter int CFG_W   = 16,
    localparam int EXT_W  = ELOW_W + PAGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CNT_W-1:0]   count_o,
    output logic               busy_o,
    output logic               irq_o,
    output logic [IADDR_W-1:0] mem_addr_o,
    output logic               mem_we_o,
    output logic [WORD_W-1:0]  mem_wdata_o,
    input  logic [WORD_W-1:0]  mem_rdata_i,
    output logic [EXT_W-1:0]   ext_addr_o,
    output logic [BYTE_W-1:0]  ext_dout_o,
    input  logic [BYTE_W-1:0]  ext_din_i,
    output logic               ext_drive_o,
    output logic               ext_ce_n_o,
    output logic               ext_we_n_o,
    output logic               ext_oe_n_o
);
    phase_e          phase;
    logic [1:0]      byte_idx;
    logic            byte_adv, word_adv, sample, start, last_word, dir_wr, busy;
    pack_e           mode;
    logic [WS_W-1:0] waits;

    assign busy = (phase != PH_IDLE);

    byte_dma_regs #(
        .IADDR_W(IADDR_W), .ELOW_W(ELOW_W), .PAGE_W(PAGE_W),
        .CNT_W(CNT_W), .WS_W(WS_W), .CFG_W(CFG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .byte_adv(byte_adv),
        .word_adv(word_adv), .iaddr(mem_addr_o), .ext_addr(ext_addr_o),
        .dir_wr(dir_wr), .mode(mode), .waits(waits), .count(count_o),
        .start(start), .last_word(last_word)
    );

    byte_dma_seq #(.WS_W(WS_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .waits(waits), .mode(mode),
        .dir_wr(dir_wr), .last_word(last_word), .phase(phase),
        .byte_idx(byte_idx), .byte_adv(byte_adv), .word_adv(word_adv),
        .sample(sample), .irq(irq_o)
    );

    byte_dma_pack u_pack (
        .clk(clk), .rst_n(rst_n), .mode(mode), .byte_idx(byte_idx),
        .sample(sample), .ext_din(ext_din_i), .mem_rdata(mem_rdata_i),
        .ext_dout(ext_dout_o), .mem_wdata(mem_wdata_o)
    );

    // External strobes and internal write, decoded from the phase.
    assign busy_o      = busy;
    assign ext_ce_n_o  = !busy;
    assign ext_we_n_o  = !((phase == PH_STROBE) && dir_wr);
    assign ext_oe_n_o  = !((phase == PH_STROBE) && !dir_wr);
    assign ext_drive_o = busy && dir_wr;
    assign mem_we_o    = word_adv && !dir_wr;
endmodule

// File: rtl/byte_dma_chk.sv
// Protocol checker for the DMA engine, attached to the top by bind.
module byte_dma_chk #(
    parameter int CNT_W = 14,
    parameter int EXT_W = 22,
    parameter int WS_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             we_n,
    input logic             oe_n,
    input logic [EXT_W-1:0] ext_addr,
    input logic             busy,
    input logic             irq,
    input logic [CNT_W-1:0] count,
    input logic             mem_we,
    input logic             dir_wr,
    input logic [WS_W-1:0]  waits
);
    logic       strb, strb_q;
    logic [7:0] run_q;

    assign strb = !we_n || !oe_n;

    // Measure the length of each strobe run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q <= 1'b0;
            run_q  <= '0;
        end else begin
            strb_q <= strb;
            run_q  <= strb ? run_q + 8'd1 : 8'd0;
        end
    end

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !oe_n));
    // R11
    strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) strb |-> !ce_n);
    // R11
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) strb |=> (!(!we_n || !oe_n) || $stable(ext_addr)));
    // R8
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n) (strb_q && !strb) |-> (run_q == 8'(waits) + 8'd1));
    // R4
    irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (count == '0 && !busy));
    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (count <= $past(count)));
    // R10
    mem_we_dir_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> !dir_wr);
endmodule

bind byte_dma_engine byte_dma_chk #(
    .CNT_W(CNT_W), .EXT_W(EXT_W), .WS_W(WS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ext_ce_n_o), .we_n(ext_we_n_o),
    .oe_n(ext_oe_n_o), .ext_addr(ext_addr_o), .busy(busy_o), .irq(irq_o),
    .count(count_o), .mem_we(mem_we_o), .dir_wr(dir_wr), .waits(waits)
);

// File: tb/byte_dma_engine_test.sv
module byte_dma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [13:0] count_o, mem_addr_o;
    logic        busy_o, irq_o, mem_we_o, ext_drive_o, ext_ce_n_o, ext_we_n_o, ext_oe_n_o;
    logic [23:0] mem_wdata_o, mem_rdata_i;
    logic [21:0] ext_addr_o;
    logic [7:0]  ext_dout_o, ext_din_i;

    logic [23:0] imem [64];
    logic [7:0]  emem [1024];
    logic [21:0] alog [16];
    int          alog_n = 0;
    int          run_len = 0, run_min = 99, run_max = 0;
    logic        strb_prev = 1'b0;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    byte_dma_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .count_o(count_o), .busy_o(busy_o), .irq_o(irq_o), .mem_addr_o(mem_addr_o),
        .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .ext_addr_o(ext_addr_o), .ext_dout_o(ext_dout_o), .ext_din_i(ext_din_i),
        .ext_drive_o(ext_drive_o), .ext_ce_n_o(ext_ce_n_o), .ext_we_n_o(ext_we_n_o),
        .ext_oe_n_o(ext_oe_n_o)
    );

    assign mem_rdata_i = imem[mem_addr_o[5:0]];
    assign ext_din_i   = emem[ext_addr_o[9:0]];

    // Memory models and strobe monitor, using values of the clock just ended.
    always @(posedge clk) begin
        if (mem_we_o) imem[mem_addr_o[5:0]] <= mem_wdata_o;
        if (!ext_we_n_o && ext_drive_o) emem[ext_addr_o[9:0]] <= ext_dout_o;
        if (rst_n) begin
            if (!ext_we_n_o || !ext_oe_n_o) begin
                if (!strb_prev && alog_n < 16) begin
                    alog[alog_n] = ext_addr_o;
                    alog_n++;
                end
                run_len++;
                strb_prev = 1'b1;
            end else begin
                if (strb_prev) begin
                    if (run_len < run_min) run_min = run_len;
                    if (run_len > run_max) run_max = run_len;
                end
                run_len = 0;
                strb_prev = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fill();
        for (int i = 0; i < 64; i++) imem[i] = {8'(i*3+1), 8'(i*5+2), 8'(i*11+9)};
        for (int i = 0; i < 1024; i++) emem[i] = 8'(i*7+3);
    endtask

    function automatic int bpw(input logic [1:0] m);
        return (m == 2'd2) ? 2 : (m == 2'd3) ? 3 : 1;
    endfunction

    function automatic logic [7:0] lane_byte(input logic [23:0] w, input logic [1:0] m, input int j);
        return (m == 2'd1) ? w[15:8] : w[j*8 +: 8];
    endfunction

    // Wait from negedge 0 for the interrupt; returns cycles counted.
    task automatic wait_irq(inout int cyc);
        while (!irq_o && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 5000) chk(1'b0, "R4", "interrupt timeout", cyc, 0);
        @(negedge clk);
        chk(!irq_o, "R4", "interrupt one clock wide", irq_o, 0);
    endtask

    typedef struct packed {
        logic        dir;
        logic [1:0]  mode;
        logic [2:0]  ws;
        logic [7:0]  words;
        logic [13:0] ia;
        logic [13:0] el;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 3'd0, 8'd4, 14'd0,  14'h010},
        '{1'b0, 2'd1, 3'd2, 8'd3, 14'd8,  14'h020},
        '{1'b0, 2'd2, 3'd1, 8'd4, 14'd16, 14'h040},
        '{1'b0, 2'd3, 3'd3, 8'd3, 14'd24, 14'h060},
        '{1'b1, 2'd2, 3'd0, 8'd4, 14'd32, 14'h100},
        '{1'b1, 2'd3, 3'd2, 8'd3, 14'd40, 14'h140},
        '{1'b1, 2'd1, 3'd1, 8'd2, 14'd48, 14'h180},
        '{1'b1, 2'd0, 3'd5, 8'd2, 14'd50, 14'h190}
    };

    initial begin
        int cyc;
        fill();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !irq_o, "R1", "idle after reset", {busy_o, irq_o}, 0);
        chk(ext_ce_n_o && ext_we_n_o && ext_oe_n_o, "R1", "strobes inactive",
            {ext_ce_n_o, ext_we_n_o, ext_oe_n_o}, 3'b111);
        chk(count_o == 0, "R1", "count zero", count_o, 0);

        // R1 default wait states 7: one LO8 read word takes 10 clocks (R8)
        wr(3'd0, 16'd60); wr(3'd1, 16'h3F0); wr(3'd2, 16'h0000);
        run_min = 99; run_max = 0;
        wr(3'd4, 16'd1);
        chk(busy_o, "R3", "busy one clock after count write", busy_o, 1);
        cyc = 0; wait_irq(cyc);
        chk(cyc == 10, "R1", "default 7 wait states transfer length", cyc, 10);
        chk(run_min == 8 && run_max == 8, "R8", "default strobe width", run_max, 8);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            automatic vec_t t = VECS[v];
            automatic int nb = bpw(t.mode);
            automatic int bad = 0;
            automatic longint ba = 0, be = 0;
            automatic logic [23:0] orig [64];
            automatic logic [7:0]  eorig [1024];
            fill();
            orig = imem; eorig = emem;
            wr(3'd0, 16'(t.ia)); wr(3'd1, 16'(t.el));
            wr(3'd2, {8'h00, 5'd0, t.dir, t.mode}); wr(3'd3, 16'(t.ws));
            run_min = 99; run_max = 0;
            wr(3'd4, 16'(t.words));
            cyc = 0; wait_irq(cyc);
            chk(cyc == int'(t.words) * nb * (int'(t.ws) + 3), "R8", $sformatf("vector %0d length", v),
                cyc, int'(t.words) * nb * (int'(t.ws) + 3));
            chk(run_min == int'(t.ws) + 1 && run_max == int'(t.ws) + 1, "R8",
                $sformatf("vector %0d strobe width", v), run_max, int'(t.ws) + 1);
            chk(count_o == 0 && !busy_o, "R4", $sformatf("vector %0d done state", v), count_o, 0);
            chk(mem_addr_o == t.ia + 14'(t.words), "R10", $sformatf("vector %0d internal address", v),
                mem_addr_o, t.ia + 14'(t.words));
            for (int k = 0; k < int'(t.words); k++) begin
                if (!t.dir) begin
                    // R6 read packing
                    automatic logic [23:0] e = '0;
                    for (int j = 0; j < nb; j++) begin
                        automatic logic [7:0] b = eorig[int'(t.el) + k*nb + j];
                        if (t.mode == 2'd1) e[15:8] = b; else e[j*8 +: 8] = b;
                    end
                    if (imem[int'(t.ia) + k] !== e && bad == 0) begin ba = imem[int'(t.ia) + k]; be = e; end
                    if (imem[int'(t.ia) + k] !== e) bad++;
                end else begin
                    // R7 write unpacking
                    for (int j = 0; j < nb; j++) begin
                        automatic logic [7:0] e = lane_byte(orig[int'(t.ia) + k], t.mode, j);
                        if (emem[int'(t.el) + k*nb + j] !== e && bad == 0) begin
                            ba = emem[int'(t.el) + k*nb + j]; be = e;
                        end
                        if (emem[int'(t.el) + k*nb + j] !== e) bad++;
                    end
                end
            end
            if (!t.dir) begin
                chk(bad == 0, "R6", $sformatf("vector %0d packed words", v), ba, be);
                chk(imem[int'(t.ia) + int'(t.words)] === orig[int'(t.ia) + int'(t.words)], "R10",
                    "word past end untouched", imem[int'(t.ia) + int'(t.words)], orig[int'(t.ia) + int'(t.words)]);
            end else begin
                chk(bad == 0, "R7", $sformatf("vector %0d unpacked bytes", v), ba, be);
                chk(emem[int'(t.el) + int'(t.words)*nb] === eorig[int'(t.el) + int'(t.words)*nb], "R7",
                    "byte past end untouched", emem[int'(t.el) + int'(t.words)*nb], eorig[int'(t.el) + int'(t.words)*nb]);
            end
        end

        // R3 count of zero starts nothing
        wr(3'd4, 16'd0);
        chk(!busy_o, "R3", "zero count does not start", busy_o, 0);
        repeat (4) @(negedge clk);
        chk(!busy_o && !irq_o && ext_ce_n_o, "R3", "still idle after zero count", busy_o, 0);

        // R9 writes while busy are ignored; R4 count polled mid-transfer
        fill();
        wr(3'd0, 16'd4); wr(3'd1, 16'h200); wr(3'd2, 16'h0000); wr(3'd3, 16'd0);
        wr(3'd4, 16'd3);
        cyc = 0;
        wr(3'd4, 16'd9); cyc++;
        wr(3'd2, 16'hFF07); cyc++;
        chk(count_o == 3, "R4", "count before first word ends", count_o, 3);
        @(negedge clk); cyc++;
        chk(count_o == 2, "R4", "count polled after first word", count_o, 2);
        wait_irq(cyc);
        chk(cyc == 9, "R9", "count rewrite while busy ignored", cyc, 9);
        chk(ext_addr_o == 22'h000203, "R9", "page write while busy ignored", ext_addr_o, 22'h000203);
        chk(imem[4] == {16'h0, emem[10'h200]}, "R9", "mode write while busy ignored", imem[4], {16'h0, emem[10'h200]});

        // R2 page carry across the 14-bit low field
        fill();
        wr(3'd0, 16'd0); wr(3'd1, 16'h3FFE); wr(3'd2, 16'h0506); wr(3'd3, 16'd1);
        alog_n = 0;
        wr(3'd4, 16'd2);
        cyc = 0; wait_irq(cyc);
        chk(alog_n == 4, "R2", "byte cycles logged", alog_n, 4);
        chk(alog[0] == 22'h017FFE && alog[1] == 22'h017FFF, "R2", "addresses before carry", alog[1], 22'h017FFF);
        chk(alog[2] == 22'h018000 && alog[3] == 22'h018001, "R2", "page carry address", alog[2], 22'h018000);
        chk(ext_addr_o == 22'h018002, "R2", "address after transfer", ext_addr_o, 22'h018002);
        chk(emem[10'h000] == imem[1][7:0], "R5", "write direction with page in control", emem[10'h000], imem[1][7:0]);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule